// File: doc/BRIEF.md
# Stacked Interrupt Status Unit

This block gathers interrupt events from a bus-side group (two detail status registers) and a DMA group (one detail status register). It exposes them to a host through a byte-wide register port. A summary register reports which groups have something pending and carries a software-clearable function flag. Each detail register returns its pending events on a read and clears them in the same access.

Every detail register has a one-entry stack behind it. An event that arrives while an earlier one is still pending is parked in the stack. Further events that arrive while the stack is occupied are merged into it. When the pending value is cleared by a read, the stacked value moves up. The active-low interrupt pin therefore stays asserted, or is asserted again, until everything has been drained.

Consecutive detail reads must be spaced by a minimum number of clocks. A read that comes too soon still returns data but does not clear anything, and it raises a one-cycle violation flag.

Top module: `irq_stack_unit`

## Requirements
- R1: Summary register (address 0) bit 0 reads 1 exactly when the DMA detail register holds a nonzero pending value.
- R2: Summary register bit 1 reads 1 exactly when either bus-side detail register (address 1 or address 2) holds a nonzero pending value. Each group clears independently of the other.
- R3: Summary register bit 2 is set by a cycle with `fly_evt` high. It is cleared by a host write to address 0 with data bit 2 set. If both happen in the same cycle, the set wins.
- R4: A host read of a detail register (address 1, 2 or 3) returns that register's pending value in the same cycle and clears it at the next clock edge.
- R5: A detail read that arrives fewer than GAP_CLKS (default 12) clocks after the previous detail read is rejected. It returns data but clears nothing, and `gap_err` is high for the one cycle after it. Every detail read, accepted or rejected, restarts the count. A read exactly GAP_CLKS clocks later is accepted.
- R6: An event that arrives while its detail register holds a nonzero pending value is ORed into that register's stack. When the pending value is cleared, the stack becomes the new pending value.
- R7: An event that arrives in the same cycle as an accepted clear of its register becomes part of the new pending value and is not lost.
- R8: `irq_n` is low exactly when (bit 0 and mask bit 0) or (bit 1 and mask bit 1) or (bit 2 and mask bit 2) holds. The mask register is at address 4, is read/write, and resets to all ones.
- R9: Reset clears all pending values, stacks and the function flag, and drives `irq_n` high and `gap_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scsi0_evt | input | 8 | Event bits for bus-side detail register 0 |
| scsi1_evt | input | 8 | Event bits for bus-side detail register 1 |
| dma_evt | input | 8 | Event bits for the DMA detail register |
| fly_evt | input | 1 | Sets the function flag |
| req_valid | input | 1 | Host access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, same cycle |
| irq_n | output | 1 | Active-low interrupt |
| gap_err | output | 1 | Read-spacing violation pulse |

## Verification
The checker watches every cycle for the following:
- a low `irq_n` always has a pending source behind it;
- a too-early detail read always raises `gap_err` and leaves the DMA pending value untouched;
- a clear with a stacked value always leaves something pending;
- no DMA event ever vanishes;
- a flag-clear write with no concurrent set always drops the flag.

Only the bench scenarios can show the exact values that each read returns. The same holds for the OR-merge in the stack, the exact spacing boundary, mask behaviour and reset in the middle of traffic.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;
  localparam int ADDR_W   = 3;
  localparam int BIT_DIP  = 0;
  localparam int BIT_SIP  = 1;
  localparam int BIT_INTF = 2;
  localparam int NSLOT    = 3;
  // register addresses; detail slot g lives at address g+1
  localparam logic [ADDR_W-1:0] A_SUM  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd4;
endpackage

// File: rtl/irq_detail_slot.sv
module irq_detail_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          clr,
  output logic [DW-1:0] posted,
  output logic [DW-1:0] stacked
);
  logic [DW-1:0] posted_d, stacked_d;

  always_comb begin
    posted_d  = posted;
    stacked_d = stacked;
    if (clr) begin
      posted_d  = stacked | evt;
      stacked_d = '0;
    end else if (posted != '0) begin
      stacked_d = stacked | evt;
    end else begin
      posted_d  = evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posted  <= '0;
      stacked <= '0;
    end else begin
      posted  <= posted_d;
      stacked <= stacked_d;
    end
  end
endmodule

// File: rtl/irq_gap_guard.sv
module irq_gap_guard #(
  parameter int GAP_CLKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_rd,
  output logic gap_ok,
  output logic gap_err
);
  localparam int CW = $clog2(GAP_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(GAP_CLKS);

  logic [CW-1:0] cnt, cnt_d;
  logic          err_d;

  assign gap_ok = (cnt >= LIMIT);

  always_comb begin
    cnt_d = cnt;
    if (det_rd)           cnt_d = CW'(1);
    else if (cnt < LIMIT) cnt_d = cnt + CW'(1);
    err_d = det_rd & ~gap_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= LIMIT;
      gap_err <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      gap_err <= err_d;
    end
  end
endmodule

// File: rtl/irq_stack_unit.sv
module irq_stack_unit
  import irq_stack_pkg::*;
#(
  parameter int DW       = 8,
  parameter int GAP_CLKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     scsi0_evt,
  input  logic [DW-1:0]     scsi1_evt,
  input  logic [DW-1:0]     dma_evt,
  input  logic              fly_evt,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              irq_n,
  output logic              gap_err
);
  logic [DW-1:0]    evt_a  [NSLOT];
  logic [DW-1:0]    post_a [NSLOT];
  logic [DW-1:0]    stk_a  [NSLOT];
  logic [NSLOT-1:0] det_sel, clr;
  logic             det_rd, gap_ok;
  logic             sip, dip, intf, intf_d;
  logic [DW-1:0]    mask, mask_d, sum_v;

  assign evt_a[0] = scsi0_evt;
  assign evt_a[1] = scsi1_evt;
  assign evt_a[2] = dma_evt;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign det_sel[g] = req_valid & ~req_write & (req_addr == ADDR_W'(g + 1));
    assign clr[g]     = det_sel[g] & gap_ok;
    irq_detail_slot #(.DW(DW)) slot_i (
      .clk(clk), .rst_n(rst_n), .evt(evt_a[g]), .clr(clr[g]),
      .posted(post_a[g]), .stacked(stk_a[g])
    );
  end

  assign det_rd = |det_sel;

  irq_gap_guard #(.GAP_CLKS(GAP_CLKS)) guard_i (
    .clk(clk), .rst_n(rst_n), .det_rd(det_rd), .gap_ok(gap_ok), .gap_err(gap_err)
  );

  assign sip = (post_a[0] != '0) | (post_a[1] != '0);
  assign dip = (post_a[2] != '0);

  always_comb begin
    intf_d = intf;
    mask_d = mask;
    if (req_valid && req_write && req_addr == A_SUM && req_wdata[BIT_INTF]) intf_d = 1'b0;
    if (fly_evt) intf_d = 1'b1;
    if (req_valid && req_write && req_addr == A_MASK) mask_d = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intf <= 1'b0;
      mask <= '1;
    end else begin
      intf <= intf_d;
      mask <= mask_d;
    end
  end

  always_comb begin
    sum_v           = '0;
    sum_v[BIT_DIP]  = dip;
    sum_v[BIT_SIP]  = sip;
    sum_v[BIT_INTF] = intf;
    rd_data = '0;
    if (req_valid && !req_write) begin
      unique case (req_addr)
        3'd0:    rd_data = sum_v;
        3'd1:    rd_data = post_a[0];
        3'd2:    rd_data = post_a[1];
        3'd3:    rd_data = post_a[2];
        3'd4:    rd_data = mask;
        default: rd_data = '0;
      endcase
    end
  end

  assign irq_n = ~((dip & mask[BIT_DIP]) | (sip & mask[BIT_SIP]) | (intf & mask[BIT_INTF]));
endmodule

// File: rtl/irq_stack_chk.sv
module irq_stack_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_n,
  input logic          gap_err,
  input logic          fly_evt,
  input logic          req_valid,
  input logic          req_write,
  input logic [2:0]    req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [DW-1:0] dma_evt,
  input logic          intf,
  input logic          det_rd,
  input logic          gap_ok,
  input logic [2:0]    clr,
  input logic [DW-1:0] post_s0,
  input logic [DW-1:0] post_s1,
  input logic [DW-1:0] post_dma,
  input logic [DW-1:0] stack_dma
);
  a_r8_pin_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (post_s0 != '0 || post_s1 != '0 || post_dma != '0 || intf));

  a_r5_gap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (det_rd && !gap_ok) |=> gap_err);

  a_r5_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (det_rd && !gap_ok && dma_evt == '0) |=> $stable(post_dma));

  a_r4_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));

  a_r6_promote: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[2] && stack_dma != '0) |=> (post_dma != '0));

  a_r7_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_evt != '0) |=> ((post_dma | stack_dma) != '0));

  a_r3_intf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 3'd0 && req_wdata[2] && !fly_evt) |=> !intf);
endmodule

bind irq_stack_unit irq_stack_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .gap_err(gap_err), .fly_evt(fly_evt),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .dma_evt(dma_evt), .intf(intf), .det_rd(det_rd),
  .gap_ok(gap_ok), .clr(clr), .post_s0(post_a[0]), .post_s1(post_a[1]),
  .post_dma(post_a[2]), .stack_dma(stk_a[2])
);

// File: tb/irq_stack_unit_tb.sv
module irq_stack_unit_tb_top;
  localparam int PERIOD = 10;
  localparam int NV = 40;
  // {kind, addr, data, exp}: kind 0 inject (addr 0 fly,1 s0,2 s1,3 dma), 1 write, 2 read-check, 3 irq_n check
  localparam logic [20:0] VEC [NV] = '{
    {2'd0,3'd3,8'h05,8'h00}, {2'd2,3'd0,8'h00,8'h01}, {2'd3,3'd0,8'h00,8'h00},
    {2'd0,3'd3,8'h20,8'h00}, {2'd2,3'd3,8'h00,8'h05}, {2'd2,3'd0,8'h00,8'h01},
    {2'd3,3'd0,8'h00,8'h00}, {2'd2,3'd3,8'h00,8'h20}, {2'd2,3'd0,8'h00,8'h00},
    {2'd3,3'd0,8'h00,8'h01}, {2'd0,3'd1,8'h02,8'h00}, {2'd0,3'd2,8'h80,8'h00},
    {2'd0,3'd3,8'h01,8'h00}, {2'd2,3'd0,8'h00,8'h03}, {2'd2,3'd1,8'h00,8'h02},
    {2'd2,3'd0,8'h00,8'h03}, {2'd2,3'd2,8'h00,8'h80}, {2'd2,3'd0,8'h00,8'h01},
    {2'd2,3'd3,8'h00,8'h01}, {2'd2,3'd0,8'h00,8'h00}, {2'd0,3'd0,8'h01,8'h00},
    {2'd2,3'd0,8'h00,8'h04}, {2'd3,3'd0,8'h00,8'h00}, {2'd1,3'd0,8'h04,8'h00},
    {2'd2,3'd0,8'h00,8'h00}, {2'd3,3'd0,8'h00,8'h01}, {2'd0,3'd3,8'h08,8'h00},
    {2'd1,3'd4,8'h06,8'h00}, {2'd3,3'd0,8'h00,8'h01}, {2'd2,3'd4,8'h00,8'h06},
    {2'd1,3'd4,8'h07,8'h00}, {2'd3,3'd0,8'h00,8'h00}, {2'd2,3'd3,8'h00,8'h08},
    {2'd0,3'd3,8'h01,8'h00}, {2'd0,3'd3,8'h02,8'h00}, {2'd0,3'd3,8'h04,8'h00},
    {2'd2,3'd3,8'h00,8'h01}, {2'd2,3'd3,8'h00,8'h06}, {2'd2,3'd0,8'h00,8'h00},
    {2'd3,3'd0,8'h00,8'h01}
  };

  logic clk, rst_n;
  logic [7:0] scsi0_evt, scsi1_evt, dma_evt, req_wdata, rd_data;
  logic fly_evt, req_valid, req_write, irq_n, gap_err;
  logic [2:0] req_addr;
  int checks, errors;
  bit done;

  irq_stack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .scsi0_evt(scsi0_evt), .scsi1_evt(scsi1_evt),
    .dma_evt(dma_evt), .fly_evt(fly_evt), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq_n(irq_n),
    .gap_err(gap_err)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    scsi0_evt = '0; scsi1_evt = '0; dma_evt = '0; fly_evt = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic inject(input logic [2:0] src, input logic [7:0] v);
    @(negedge clk);
    case (src)
      3'd0: fly_evt = 1'b1;
      3'd1: scsi0_evt = v;
      3'd2: scsi1_evt = v;
      default: dma_evt = v;
    endcase
    @(posedge clk); #1 clear_inputs();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1 clear_inputs();
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 chk(tag, rd_data, exp);
    @(posedge clk); #1 clear_inputs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    clear_inputs();
    rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state
    chk("R9 irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk("R9 gap_err after reset", {7'd0, gap_err}, 8'h00);
    rd(3'd0, 8'h00, "R9 summary after reset");
    rd(3'd4, 8'hFF, "R8 mask reset value");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k; logic [2:0] a; logic [7:0] d, e;
      {k, a, d, e} = VEC[i];
      case (k)
        2'd0: inject(a, d);
        2'd1: wr(a, d);
        2'd2: begin
          if (a == 3'd0)      rd(a, e, "R1_R2_R3 summary");
          else if (a == 3'd4) rd(a, e, "R8 mask readback");
          else                rd(a, e, "R4_R6 detail read");
          idle(13);
        end
        default: begin
          idle(2);
          @(negedge clk) chk("R8 irq_n level", {7'd0, irq_n}, e);
        end
      endcase
    end

    // R5 spacing: rejected at 11 clocks, accepted at exactly 12
    idle(13);
    inject(3'd1, 8'h11);
    inject(3'd3, 8'h40);
    rd(3'd3, 8'h40, "R4 dma read");
    chk("R5 no flag on spaced read", {7'd0, gap_err}, 8'h00);
    idle(10);
    rd(3'd1, 8'h11, "R5 early read data");
    chk("R5 flag on early read", {7'd0, gap_err}, 8'h01);
    idle(1);
    #1 chk("R5 flag lasts one cycle", {7'd0, gap_err}, 8'h00);
    idle(10);
    rd(3'd1, 8'h11, "R5 not cleared by early read");
    chk("R5 boundary read accepted", {7'd0, gap_err}, 8'h00);
    idle(13);
    rd(3'd1, 8'h00, "R5 boundary read cleared");

    // R7 event in the same cycle as its clear
    idle(13);
    inject(3'd3, 8'h02);
    @(negedge clk);
    dma_evt = 8'h10; req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd3;
    #1 chk("R7 read before merge", rd_data, 8'h02);
    @(posedge clk); #1 clear_inputs();
    idle(13);
    rd(3'd3, 8'h10, "R7 event kept");
    idle(13);
    rd(3'd3, 8'h00, "R7 drained");

    // R3 set wins over clear
    @(negedge clk);
    fly_evt = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_wdata = 8'h04;
    @(posedge clk); #1 clear_inputs();
    rd(3'd0, 8'h04, "R3 set wins");
    wr(3'd0, 8'h04);
    rd(3'd0, 8'h00, "R3 cleared by write");

    // R9 reset in the middle of traffic
    inject(3'd2, 8'h55);
    inject(3'd2, 8'hAA);
    inject(3'd0, 8'h01);
    @(negedge clk) chk("R2 irq_n before reset", {7'd0, irq_n}, 8'h00);
    rst_n = 1'b0;
    idle(2);
    @(negedge clk) rst_n = 1'b1;
    chk("R9 irq_n cleared", {7'd0, irq_n}, 8'h01);
    rd(3'd0, 8'h00, "R9 summary cleared");
    rd(3'd2, 8'h00, "R9 posted cleared");
    idle(13);
    rd(3'd2, 8'h00, "R9 stack cleared");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule